// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills every word of a switch connection memory with one value in a fixed time. Software writes a 5-bit fill value and an arm bit into the mode register. It also sets a block-mode bit in the control register. The engine then waits for the next frame boundary. On each time-slot tick it writes one word, in ascending address order. Each word carries the fill value in its top five bits and zeros in all lower bits. With half the memory written per frame, a full pass takes exactly two frames. At the end the engine drops the arm bit by itself.

While a fill is pending or running, `busy_o` is high. During that time the block takes the memory write port from the host, and host write requests are discarded. When the block is idle, host writes reach the memory port unchanged in the same cycle. If block mode is off, arming does nothing: the arm bit falls back to zero on the next clock.

Top module: `cmem_fill`

## Requirements
- R1: After reset, `busy_o`, `fill_en_o` and `cm_we_o` are low, with no host write requested.
- R2: A register write with `reg_sel_i`=0 loads the fill value from `reg_wdata_i[9:5]` and the arm bit from `reg_wdata_i[13]`. A write with `reg_sel_i`=1 loads the block-mode bit from `reg_wdata_i[15]`. `fill_en_o` shows the arm bit in the cycle after the write.
- R3: If the arm bit is set while block mode is 0, the arm bit reads 1 for exactly one cycle and then 0. No memory write is issued and `busy_o` stays low.
- R4: If the arm bit is set while block mode is 1, `busy_o` rises one clock after `fill_en_o` reads 1. The first fill write goes to address 0, in a cycle where both `frame_i` and `slot_tick_i` are high.
- R5: Every fill write carries the captured fill value in bits 15:11 and zeros in bits 10:0.
- R6: Fill writes are presented combinationally in the cycle of a slot tick, at most one per tick. No fill write appears in a cycle without a tick. The addresses run 0, 1, 2, … up to DEPTH-1 with no gaps.
- R7: A fill issues exactly DEPTH writes, half per frame. The last write falls on the final tick of the second frame, 2·(DEPTH-1) clock cycles after the first write when ticks come every other cycle.
- R8: After the clock edge that takes the last fill write, `busy_o` and `fill_en_o` are both 0.
- R9: When idle, a host write shows up on `cm_we_o`/`cm_addr_o`/`cm_wdata_o` in the same cycle. While `busy_o` is high, host writes never reach the memory port.
- R10: The fill value is captured when the fill is armed. Mode-register writes during a fill change neither the data being written nor the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle pulse per time slot |
| frame_i | input | 1 | High with the tick of slot 0 of each frame |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = mode register, 1 = control register |
| reg_wdata_i | input | 16 | Register write data |
| host_we_i | input | 1 | Host connection memory write request |
| host_addr_i | input | ADDR_W | Host write address |
| host_wdata_i | input | 16 | Host write data |
| cm_we_o | output | 1 | Connection memory write enable |
| cm_addr_o | output | ADDR_W | Connection memory write address |
| cm_wdata_o | output | 16 | Connection memory write data |
| fill_en_o | output | 1 | Current arm bit (cleared by the engine) |
| busy_o | output | 1 | Fill pending or in progress |

## Verification
Two situations are hard to reach from the ports. The first is a host write that arrives mid-fill, aimed at an address the fill has already passed. The second is a mode-register rewrite during a running fill. In both cases a bad design leaves a visible trace only if the bench replays every memory write into its own model. The stimulus therefore waits until the bench's count of fill writes passes the target address, and only then issues the host write and the register rewrite in a cycle without a tick. The final memory image then shows whether the block leaked the write or took the new value.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int DATA_W  = 16;
  localparam int PAT_W   = 5;
  localparam int PAT_LSB = 11;
  // register field positions
  localparam int FV_LO   = 5;
  localparam int FV_HI   = FV_LO + PAT_W - 1;
  localparam int ARM_BIT = 13;
  localparam int BLK_BIT = 15;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cmf_regs.sv
module cmf_regs
  import cmf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              clr_i,
  output logic [PAT_W-1:0]  pat_o,
  output logic              en_o,
  output logic              mode_o
);
  logic [PAT_W-1:0] pat_q;
  logic             en_q;
  logic             mode_q;
  logic             unused_bits;

  assign unused_bits = ^{wdata_i[14], wdata_i[12:10], wdata_i[4:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (clr_i) en_q <= 1'b0;
      if (we_i && !sel_i) begin
        pat_q <= wdata_i[FV_HI:FV_LO];
        if (!busy_i) en_q <= wdata_i[ARM_BIT];  // arm bit owned by engine while busy
      end
      if (we_i && sel_i) mode_q <= wdata_i[BLK_BIT];
    end
  end

  assign pat_o  = pat_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && en_q && !clr_i |=> en_q);
endmodule

// File: rtl/cmf_seq.sv
module cmf_seq
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_tick_i,
  input  logic              frame_i,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [PAT_W-1:0]  pat_i,
  output logic              busy_o,
  output logic              clr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  fill_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic              go_now;
  logic              last_wr;

  assign go_now  = (st_q == ST_ARM) && frame_i && slot_tick_i;
  assign last_wr = (st_q == ST_FILL) && slot_tick_i && (addr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      pat_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en_i && mode_i) begin
          st_q   <= ST_ARM;
          pat_q  <= pat_i;
          addr_q <= '0;
        end
        ST_ARM: if (go_now) begin
          st_q   <= ST_FILL;
          addr_q <= addr_q + 1'b1;
        end
        ST_FILL: if (slot_tick_i) begin
          if (last_wr) st_q <= ST_IDLE;
          else         addr_q <= addr_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign clr_o   = ((st_q == ST_IDLE) && en_i && !mode_i) || last_wr;
  assign we_o    = go_now || ((st_q == ST_FILL) && slot_tick_i);
  assign addr_o  = addr_q;
  assign wdata_o = {pat_q, {PAT_LSB{1'b0}}};

  p_arm_addr0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && en_i && mode_i |=> (st_q == ST_ARM) && (addr_q == '0));
endmodule

// File: rtl/cmf_arb.sv
module cmf_arb
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              fill_we_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_wdata_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    if (busy_i) begin
      we_o    = fill_we_i;
      addr_o  = fill_addr_i;
      wdata_o = fill_wdata_i;
    end else begin
      we_o    = host_we_i;
      addr_o  = host_addr_i;
      wdata_o = host_wdata_i;
    end
  end

  p_host_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && host_we_i && !fill_we_i |-> !we_o);
endmodule

// File: rtl/cmem_fill.sv
module cmem_fill
  import cmf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_tick_i,
  input  logic              frame_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_wdata_o,
  output logic              fill_en_o,
  output logic              busy_o
);
  logic [PAT_W-1:0]  pat;
  logic              en;
  logic              blk_mode;
  logic              busy;
  logic              clr;
  logic              f_we;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_wdata;

  cmf_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .clr_i   (clr),
    .pat_o   (pat),
    .en_o    (en),
    .mode_o  (blk_mode)
  );

  cmf_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_tick_i (slot_tick_i),
    .frame_i     (frame_i),
    .en_i        (en),
    .mode_i      (blk_mode),
    .pat_i       (pat),
    .busy_o      (busy),
    .clr_o       (clr),
    .we_o        (f_we),
    .addr_o      (f_addr),
    .wdata_o     (f_wdata)
  );

  cmf_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .fill_we_i    (f_we),
    .fill_addr_i  (f_addr),
    .fill_wdata_i (f_wdata),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .we_o         (cm_we_o),
    .addr_o       (cm_addr_o),
    .wdata_o      (cm_wdata_o)
  );

  assign fill_en_o = en;
  assign busy_o    = busy;

  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !blk_mode && !busy && !reg_we_i |=> !fill_en_o && !busy_o);
  p_tick_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cm_we_o |-> slot_tick_i);
  p_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cm_we_o |-> cm_wdata_o[PAT_LSB-1:0] == '0);
  p_start_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cm_we_o && (cm_addr_o == '0) |-> frame_i);
  p_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !fill_en_o);
endmodule

// File: tb/sim_cmem_fill.sv
module sim_cmem_fill;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 7;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = DEPTH / 2;
  // {block mode, fill value}
  localparam logic [5:0] VEC [0:3] = '{6'h35, 6'h0A, 6'h3F, 6'h20};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        cm_we, fill_en, busy;
  logic [ADDR_W-1:0] cm_addr;
  logic [15:0] cm_wdata;
  logic        slot_tick, frame;
  int          cnt = 0;

  int n_chk = 0, n_bad = 0;
  int fa = 0, nfill = 0, first_t = 0, last_t = 0;
  logic [4:0]  exp_pat = '0;
  logic [15:0] mem [DEPTH];
  logic        saw_busy = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1;
  assign slot_tick = cnt[0];
  assign frame     = slot_tick && (((cnt >> 1) % SLOTS) == 0);

  cmem_fill #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slot_tick_i(slot_tick), .frame_i(frame),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .cm_we_o(cm_we), .cm_addr_o(cm_addr), .cm_wdata_o(cm_wdata),
    .fill_en_o(fill_en), .busy_o(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk); #2;
  endtask

  task automatic reg_wr(input logic sel, input logic [15:0] d);
    nxt(); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    nxt(); reg_we = 1'b0;
  endtask

  task automatic host_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic thru);
    nxt(); host_we = 1'b1; host_addr = a; host_wdata = d;
    #1;
    if (thru) begin  // R9 pass-through when idle
      chk(cm_we && cm_addr == a && cm_wdata == d, "R9 pass", {cm_we, cm_addr, cm_wdata}, {1'b1, a, d});
    end else begin   // R9 blocked while busy
      chk(!cm_we, "R9 block", cm_we, 0);
    end
    nxt(); host_we = 1'b0;
  endtask

  function automatic logic [15:0] mode_word(input logic arm, input logic [4:0] p);
    return (16'(arm) << 13) | (16'(p) << 5);
  endfunction

  // monitor: sampled well after inputs settle, before next rising edge
  always @(negedge clk) begin
    #3;
    if (rst_n && busy) saw_busy = 1'b1;
    if (rst_n && busy && cm_we) begin
      chk(slot_tick, "R6 tick", slot_tick, 1);
      chk(int'(cm_addr) == fa, "R6 addr", cm_addr, fa);
      chk(cm_wdata == {exp_pat, 11'b0}, "R5 data", cm_wdata, {exp_pat, 11'b0});
      if (fa == 0) begin
        chk(frame, "R4 frame start", frame, 1);
        first_t = cnt;
      end
      last_t = cnt;
      fa++;
      nfill++;
    end
    if (cm_we) mem[cm_addr] = cm_wdata;
  end

  task automatic wait_idle();
    while (busy) nxt();
  endtask

  task automatic check_fill(input logic [4:0] p, input string tag);
    int bad;
    chk(!busy && !fill_en, "R8 done", {busy, fill_en}, 0);
    chk(nfill == DEPTH, "R7 count", nfill, DEPTH);
    chk(last_t - first_t == 2 * (DEPTH - 1), "R7 span", last_t - first_t, 2 * (DEPTH - 1));
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== {p, 11'b0}) bad++;
    chk(bad == 0, {"R5 image ", tag}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h5A5A;
    nxt(); nxt();
    chk(!busy && !fill_en && !cm_we, "R1 reset", {busy, fill_en, cm_we}, 0);
    rst_n = 1'b1;
    nxt();
    chk(!busy && !fill_en && !cm_we, "R1 after release", {busy, fill_en, cm_we}, 0);

    for (int v = 0; v < 4; v++) begin
      logic m;
      logic [4:0] p;
      m = VEC[v][5];
      p = VEC[v][4:0];
      host_wr(7'd3, 16'hFFFF, 1'b1);
      reg_wr(1'b1, 16'(m) << 15);
      fa = 0; nfill = 0; saw_busy = 1'b0; exp_pat = p;
      reg_wr(1'b0, mode_word(1'b1, p));
      chk(fill_en && !busy, "R2 arm readback", {fill_en, busy}, 2);
      nxt();
      if (m) begin
        chk(busy, "R4 busy rise", busy, 1);
        wait_idle();
        check_fill(p, "table");
      end else begin
        chk(!fill_en, "R3 arm drop", fill_en, 0);
        repeat (300) nxt();
        chk(!saw_busy && nfill == 0, "R3 no fill", nfill, 0);
        chk(mem[3] == 16'hFFFF, "R3 memory kept", mem[3], 16'hFFFF);
      end
    end

    // R9/R10: host write and mode rewrite in mid-fill
    reg_wr(1'b1, 16'h8000);
    fa = 0; nfill = 0; exp_pat = 5'h0C;
    reg_wr(1'b0, mode_word(1'b1, 5'h0C));
    while (fa <= 20) nxt();
    while (slot_tick) nxt();
    host_we = 1'b1; host_addr = 7'd10; host_wdata = 16'hABCD;
    #1;
    chk(!cm_we, "R9 block", cm_we, 0);
    nxt(); host_we = 1'b0;
    reg_wr(1'b0, mode_word(1'b0, 5'h03));
    chk(fill_en && busy, "R10 arm held", {fill_en, busy}, 3);
    wait_idle();
    check_fill(5'h0C, "R10");
    chk(mem[10] == 16'h6000, "R9 host ignored", mem[10], 16'h6000);

    // R2: stored fill value changed after the fill is used by the next fill
    reg_wr(1'b0, mode_word(1'b1, 5'h03));
    fa = 0; nfill = 0; exp_pat = 5'h03;
    nxt();
    wait_idle();
    check_fill(5'h03, "R2 new value");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule